// File: doc/BRIEF.md
# System Address Decoder with Peripheral Window

This block turns the address and strobes of a processor with a 24-bit byte address bus and a 16-bit data bus into the active-low chip selects for its memories and one peripheral. The lowest 4 MB of the space is cut into eight regions of 512K each. The lowest four regions go to ROM rows. The next region is an I/O area. The top three regions go to SRAM rows. Any address at or above 0x400000 selects nothing.

Inside the I/O area, a second decode stage compares every upper address bit. It selects an eight-register byte peripheral only at 0x200010 through 0x200017 and passes the low three address bits to it as a register index. The block also routes the processor read strobe to the ROM and SRAM output enables and the write strobe to the SRAM write enable. The peripheral drives only the low byte of the data bus, so the block returns its byte zero-extended onto the 16-bit read lane.

A debug view reports the decoded region index and one hit flag for each region. The whole block is combinational: outputs follow the inputs in the same cycle. It has no data stream, so it uses no valid/ready handshake and applies no back-pressure.

Top module: `sys_addr_decode`

## Requirements
- R1: When address bit 23 or bit 22 is 1 (address 0x400000 and above), every chip select (rom_cs_n, io_cs_n, sram_cs_n, per_cs_n) is high, dbg_hit is all zero and dbg_region is 0.
- R2: rom_cs_n[i] is low exactly when the address lies in i*0x80000 to i*0x80000+0x7FFFF, for i = 0..3, which covers 0x000000 to 0x1FFFFF.
- R3: io_cs_n is low exactly for addresses 0x200000 to 0x27FFFF.
- R4: sram_cs_n[j] is low exactly when the address lies in 0x280000+j*0x80000 to 0x280000+j*0x80000+0x7FFFF, for j = 0..2.
- R5: At most one of the eight region selects (four ROM, one I/O, three SRAM) is low for any address.
- R6: per_cs_n is low exactly for addresses 0x200010 to 0x200017. Changing any single address bit from 3 through 23 away from 0x200010 deselects the peripheral. Whenever per_cs_n is low, io_cs_n is also low.
- R7: per_rs equals address bits 2..0 while per_cs_n is low, and is 0 otherwise.
- R8: rom_oe_n and sram_oe_n both equal rd_n, and sram_we_n equals wr_n, for every address.
- R9: host_rdata is {8'h00, per_rdata} while per_cs_n and rd_n are both low, and is 0 otherwise.
- R10: For addresses below 0x400000, dbg_region equals address bits 21..19 and dbg_hit is one-hot with bit dbg_region set. dbg_hit[k] is 1 exactly when region k is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | 24 | Processor byte address |
| rd_n | input | 1 | Processor read strobe, active low |
| wr_n | input | 1 | Processor write strobe, active low |
| per_rdata | input | 8 | Read byte from the peripheral |
| rom_cs_n | output | 4 | ROM row selects, active low |
| io_cs_n | output | 1 | I/O area select, active low |
| sram_cs_n | output | 3 | SRAM row selects, active low |
| per_cs_n | output | 1 | Peripheral select, active low |
| per_rs | output | 3 | Peripheral register index |
| rom_oe_n | output | 1 | ROM output enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| host_rdata | output | 16 | Peripheral byte zero-extended onto the data bus |
| dbg_region | output | 3 | Decoded region index |
| dbg_hit | output | 8 | One hit flag per region |

## Verification
The peripheral window is the hardest case to reach. It is 8 bytes wide inside a 512K region, and a fault in one of its 21 compared bits shows only at an address that differs from the window in that bit alone. A random sweep almost never hits such an address. The stimulus therefore crosses every value of address bits 23..16 with a set of low-half patterns that sit on and around the window edges. It then walks a single flipped bit, one position at a time, across bits 3 through 23 of 0x200010, so that each compared bit is shown to matter on its own.

// File: rtl/addr_map_pkg.sv
package addr_map_pkg;
  // Bus geometry
  localparam int unsigned ADDR_W     = 24;
  localparam int unsigned DATA_W     = 16;
  localparam int unsigned PER_DATA_W = 8;
  // Region layout: index bits sit directly above the in-region offset
  localparam int unsigned REGION_W   = 3;
  localparam int unsigned OFFSET_W   = 19;
  localparam int unsigned NREGION    = 1 << REGION_W;
  // Region allocation, lowest index first
  localparam int unsigned ROM_ROWS   = 4;
  localparam int unsigned IO_INDEX   = ROM_ROWS;
  localparam int unsigned SRAM_FIRST = IO_INDEX + 1;
  localparam int unsigned SRAM_ROWS  = NREGION - SRAM_FIRST;
  // Peripheral window
  localparam int unsigned REG_SEL_W  = 3;
  localparam logic [ADDR_W-1:0] PER_BASE = 24'h200010;
endpackage

// File: rtl/region_decode.sv
module region_decode #(
  parameter int unsigned HI_W     = 5,
  parameter int unsigned REGION_W = 3
) (
  input  logic [HI_W-1:0]              addr_hi,
  output logic [REGION_W-1:0]          idx,
  output logic [(1<<REGION_W)-1:0]     hit
);
  localparam int unsigned NREG   = 1 << REGION_W;
  localparam int unsigned GUARD_W = HI_W - REGION_W;

  logic enable;

  // Guard bits above the region index must all be zero
  assign enable = (addr_hi[HI_W-1 -: GUARD_W] == '0);
  assign idx    = enable ? addr_hi[REGION_W-1:0] : '0;

  for (genvar g = 0; g < NREG; g++) begin : g_hit
    assign hit[g] = enable && (addr_hi[REGION_W-1:0] == REGION_W'(g));
  end
endmodule

// File: rtl/periph_window.sv
module periph_window #(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned REG_SEL_W = 3,
  parameter logic [ADDR_W-1:0] BASE = 24'h200010
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 region_hit,
  output logic                 sel,
  output logic [REG_SEL_W-1:0] rs
);
  localparam int unsigned TAG_W = ADDR_W - REG_SEL_W;
  localparam logic [TAG_W-1:0] BASE_TAG = BASE[ADDR_W-1:REG_SEL_W];

  logic tag_match;

  // Full decode: every bit above the register index is compared
  assign tag_match = (addr[ADDR_W-1:REG_SEL_W] == BASE_TAG);
  assign sel       = region_hit && tag_match;
  assign rs        = sel ? addr[REG_SEL_W-1:0] : '0;
endmodule

// File: rtl/strobe_route.sv
module strobe_route #(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned PER_DATA_W = 8
) (
  input  logic                  rd_n,
  input  logic                  wr_n,
  input  logic                  per_sel,
  input  logic [PER_DATA_W-1:0] per_rdata,
  output logic                  rom_oe_n,
  output logic                  sram_oe_n,
  output logic                  sram_we_n,
  output logic [DATA_W-1:0]     host_rdata
);
  localparam int unsigned PAD_W = DATA_W - PER_DATA_W;

  assign rom_oe_n  = rd_n;
  assign sram_oe_n = rd_n;
  assign sram_we_n = wr_n;

  // Peripheral occupies the low byte lane only
  always_comb begin
    host_rdata = '0;
    if (per_sel && !rd_n) host_rdata = {{PAD_W{1'b0}}, per_rdata};
  end
endmodule

// File: rtl/sys_addr_decode.sv
module sys_addr_decode
  import addr_map_pkg::*;
#(
  parameter int unsigned P_ADDR_W = ADDR_W
) (
  input  logic [P_ADDR_W-1:0]   addr,
  input  logic                  rd_n,
  input  logic                  wr_n,
  input  logic [PER_DATA_W-1:0] per_rdata,
  output logic [ROM_ROWS-1:0]   rom_cs_n,
  output logic                  io_cs_n,
  output logic [SRAM_ROWS-1:0]  sram_cs_n,
  output logic                  per_cs_n,
  output logic [REG_SEL_W-1:0]  per_rs,
  output logic                  rom_oe_n,
  output logic                  sram_oe_n,
  output logic                  sram_we_n,
  output logic [DATA_W-1:0]     host_rdata,
  output logic [REGION_W-1:0]   dbg_region,
  output logic [NREGION-1:0]    dbg_hit
);
  localparam int unsigned HI_W = P_ADDR_W - OFFSET_W;

  logic [NREGION-1:0]  hit;
  logic [REGION_W-1:0] idx;
  logic                per_sel;

  region_decode #(.HI_W(HI_W), .REGION_W(REGION_W)) u_region (
    .addr_hi (addr[P_ADDR_W-1:OFFSET_W]),
    .idx     (idx),
    .hit     (hit)
  );

  periph_window #(.ADDR_W(P_ADDR_W), .REG_SEL_W(REG_SEL_W),
                  .BASE(P_ADDR_W'(PER_BASE))) u_window (
    .addr       (addr),
    .region_hit (hit[IO_INDEX]),
    .sel        (per_sel),
    .rs         (per_rs)
  );

  strobe_route #(.DATA_W(DATA_W), .PER_DATA_W(PER_DATA_W)) u_strobe (
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .per_sel    (per_sel),
    .per_rdata  (per_rdata),
    .rom_oe_n   (rom_oe_n),
    .sram_oe_n  (sram_oe_n),
    .sram_we_n  (sram_we_n),
    .host_rdata (host_rdata)
  );

  for (genvar i = 0; i < ROM_ROWS; i++) begin : g_rom
    assign rom_cs_n[i] = ~hit[i];
  end
  for (genvar j = 0; j < SRAM_ROWS; j++) begin : g_sram
    assign sram_cs_n[j] = ~hit[SRAM_FIRST + j];
  end

  assign io_cs_n    = ~hit[IO_INDEX];
  assign per_cs_n   = ~per_sel;
  assign dbg_region = idx;
  assign dbg_hit    = hit;
endmodule

// File: rtl/sys_addr_decode_chk.sv
module sys_addr_decode_chk
  import addr_map_pkg::*;
(
  input logic [ADDR_W-1:0]    addr,
  input logic [ROM_ROWS-1:0]  rom_cs_n,
  input logic                 io_cs_n,
  input logic [SRAM_ROWS-1:0] sram_cs_n,
  input logic                 per_cs_n,
  input logic [REG_SEL_W-1:0] per_rs,
  input logic [NREGION-1:0]   dbg_hit
);
  logic [NREGION-1:0] sel_act;
  assign sel_act = ~{sram_cs_n, io_cs_n, rom_cs_n};

  always_comb begin
    // R5: region selects are mutually exclusive
    a_r5_one_region: assert ($onehot0(sel_act));
    // R6: peripheral select lies inside the I/O area
    a_r6_per_in_io: assert (per_cs_n || !io_cs_n);
    // R1: nothing selected above the mapped 4 MB
    a_r1_high_unmapped: assert ((addr[ADDR_W-1:ADDR_W-2] == 2'b00) ||
                                (sel_act == '0 && per_cs_n));
    // R7: register index follows the low address bits while selected
    a_r7_rs_follows: assert (per_cs_n || per_rs == addr[REG_SEL_W-1:0]);
    // R10: debug hits mirror the chip selects
    a_r10_hit_match: assert (dbg_hit == sel_act);
  end
endmodule

bind sys_addr_decode sys_addr_decode_chk u_chk (
  .addr      (addr),
  .rom_cs_n  (rom_cs_n),
  .io_cs_n   (io_cs_n),
  .sram_cs_n (sram_cs_n),
  .per_cs_n  (per_cs_n),
  .per_rs    (per_rs),
  .dbg_hit   (dbg_hit)
);

// File: tb/sys_addr_decode_test.sv
module sys_addr_decode_test;
  logic        clk = 1'b0;
  logic [23:0] addr = 24'hFFFFFF;
  logic        rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0]  per_rdata = 8'h00;
  logic [3:0]  rom_cs_n;
  logic        io_cs_n;
  logic [2:0]  sram_cs_n;
  logic        per_cs_n;
  logic [2:0]  per_rs;
  logic        rom_oe_n, sram_oe_n, sram_we_n;
  logic [15:0] host_rdata;
  logic [2:0]  dbg_region;
  logic [7:0]  dbg_hit;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  sys_addr_decode uut (
    .addr(addr), .rd_n(rd_n), .wr_n(wr_n), .per_rdata(per_rdata),
    .rom_cs_n(rom_cs_n), .io_cs_n(io_cs_n), .sram_cs_n(sram_cs_n),
    .per_cs_n(per_cs_n), .per_rs(per_rs), .rom_oe_n(rom_oe_n),
    .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .host_rdata(host_rdata),
    .dbg_region(dbg_region), .dbg_hit(dbg_hit)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%h got=%h exp=%h", req, addr, got, exp);
    end
  endtask

  // Drive one probe and compare every output against the arithmetic map
  task automatic probe(input logic [23:0] a, input logic r, input logic w, input logic [7:0] d);
    int unsigned ua;
    logic [3:0] e_rom;
    logic [2:0] e_sram;
    logic       e_io, e_per;
    logic [7:0] e_hit;
    logic [2:0] e_reg;
    @(negedge clk);
    addr = a; rd_n = r; wr_n = w; per_rdata = d;
    #1;
    ua = a;
    e_hit = '0; e_reg = '0;
    if (ua < 32'h400000) begin
      e_reg = 3'(ua / 32'h80000);
      e_hit[e_reg] = 1'b1;
    end
    for (int i = 0; i < 4; i++)
      e_rom[i] = !(ua >= i*32'h80000 && ua < (i+1)*32'h80000);
    for (int j = 0; j < 3; j++)
      e_sram[j] = !(ua >= 32'h280000 + j*32'h80000 && ua < 32'h300000 + j*32'h80000);
    e_io  = !(ua >= 32'h200000 && ua < 32'h280000);
    e_per = !(ua >= 32'h200010 && ua <= 32'h200017);
    if (ua >= 32'h400000) chk("R1", {io_cs_n, per_cs_n, rom_cs_n, sram_cs_n, dbg_hit},
                              {1'b1, 1'b1, 4'hF, 3'h7, 8'h00});
    chk("R2", rom_cs_n, e_rom);
    chk("R3", io_cs_n, e_io);
    chk("R4", sram_cs_n, e_sram);
    chk("R5", $countones(~{sram_cs_n, io_cs_n, rom_cs_n}) <= 1, 1);
    chk("R6", per_cs_n, e_per);
    chk("R7", per_rs, e_per ? 3'd0 : 3'(ua % 8));
    chk("R8", {rom_oe_n, sram_oe_n, sram_we_n}, {r, r, w});
    chk("R9", host_rdata, (!e_per && !r) ? {8'h00, d} : 16'h0000);
    chk("R10", {dbg_region, dbg_hit}, {e_reg, e_hit});
  endtask

  initial begin
    logic [15:0] lows [12] = '{16'h0000, 16'h0010, 16'h0013, 16'h0017,
                               16'h0018, 16'h000F, 16'h0110, 16'h1010,
                               16'h8017, 16'hFFFF, 16'h0008, 16'h7FF0};
    int seq = 0;
    // Idle state with an unmapped address: R1
    probe(24'hFFFFFF, 1'b1, 1'b1, 8'h00);
    // Sweep all values of bits 23..16 against edge-heavy low patterns
    for (int hi = 0; hi < 256; hi++) begin
      for (int k = 0; k < 12; k++) begin
        seq++;
        probe({8'(hi), lows[k]}, seq[0], seq[1], 8'(seq * 37));
      end
    end
    // Every register of the peripheral window, read strobe low: R6 R7 R9
    for (int r = 0; r < 8; r++) probe(24'h200010 + 24'(r), 1'b0, 1'b1, 8'hA0 + 8'(r));
    // Single-bit escapes from the window: R6
    for (int b = 3; b < 24; b++) probe(24'h200010 ^ (24'h1 << b), 1'b0, 1'b0, 8'h5A);
    // Region boundaries: R2 R3 R4 R10
    for (int g = 0; g <= 8; g++) begin
      probe(24'(g * 32'h80000), 1'b0, 1'b1, 8'h11);
      if (g > 0) probe(24'(g * 32'h80000 - 1), 1'b1, 1'b0, 8'h22);
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired after %0d cycles", cyc);
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule